// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Bus Handshake

This block moves a block of words between a peripheral and memory so that the processor does not handle each word itself. Software loads a start address and a word count, picks a mode and a direction, then writes the start bit. The engine raises its bus request and waits for the processor's grant. Only while the grant is present does it drive the shared address bus and strobe memory and the peripheral. After each word it steps the address by one and lowers the remaining count.

Two tenure policies are offered. In block mode all words go across in consecutive clock cycles under one grant. In steal mode the engine takes a single word per grant and then hands the bus back. The processor grants at its instruction boundaries, so one memory cycle is taken per instruction. When the count reaches zero, the engine drops its request and waits for the grant to fall. It then sets a done flag, which is also the interrupt line. Touching the status register clears that flag.

Top module: `dma_engine`

## Requirements
- R1: The engine drives the bus (bus_oe, mem_we, mem_re, dev_rd, dev_wr) only in a cycle where bus_grant and bus_req are both high.
- R2: When bus_oe is low, bus_addr is all zeros. When bus_oe is high, bus_addr carries the memory address of the word being moved.
- R3: The register map uses reg_sel 0 for the address, 1 for the count and 2 for control. Control bit 0 is the start bit, which always reads as 0. Control bit 1 selects steal mode (1) or block mode (0). Control bit 2 selects the direction: 0 moves device to memory, 1 moves memory to device. reg_sel 3 is status, with bit 0 for busy and bit 1 for done. reg_rdata shows the selected register in the same cycle.
- R4: In block mode a nonzero count is moved under a single grant, and bus_req stays high between words.
- R5: In steal mode bus_req falls after every word, so a count of N takes N separate grants.
- R6: When it gives up the bus, the engine keeps bus_req low until it sees bus_grant low. It never raises bus_req while bus_grant is still high.
- R7: irq equals the done flag. done rises one cycle after the engine has seen bus_grant low following the last word.
- R8: A read or write access with reg_sel 3 clears done (and irq) at the next edge. Writing the start bit also clears it. A completion in the same cycle takes priority over the clear.
- R9: Starting with a count of 0 sets done at the next edge and never raises bus_req.
- R10: Each moved word increments the address by one and decrements the count by one. After completion the address reads start plus count and the count reads 0.
- R11: Writes to the address, count or control register while busy have no effect.
- R12: With direction 0, dev_rdata is written to memory at bus_addr and dev_rd pulses. With direction 1, mem_rdata is passed to dev_wdata and dev_wr pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed to clear status) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| bus_req | output | 1 | Request for the shared bus |
| bus_grant | input | 1 | Grant from the processor |
| bus_oe | output | 1 | Engine drives the bus this cycle |
| bus_addr | output | AW | Memory address, zero when not driving |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Data to memory |
| mem_rdata | input | DW | Data from memory |
| dev_rd | output | 1 | Pop one word from the peripheral |
| dev_rdata | input | DW | Word offered by the peripheral |
| dev_wr | output | 1 | Push one word into the peripheral |
| dev_wdata | output | DW | Word to the peripheral |
| irq | output | 1 | Completion interrupt (done flag) |

## Verification
A wrong address counter shows up at once on bus_addr during the next bus cycle, and after the transfer it lands the data at the wrong memory locations. A count register that is off by one lengthens or shortens the tenure by a word, which the per-run bus cycle count exposes. A sequencer stuck in the wrong state either drives without a grant in that same cycle, requests too many or too few grants per run, or never raises irq, which trips the wait timeout within a few hundred cycles. A done flag that is not cleared keeps irq high in the cycle after a status access.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_GO    = 0;
  localparam int CTRL_STEAL = 1;
  localparam int CTRL_DIR   = 2;

  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          finish,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic          mode_steal,
  output logic          dir,
  output logic          go_pulse,
  output logic          done
);
  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  logic wr_addr, wr_cnt, wr_ctrl, stat_touch;

  assign wr_addr    = reg_wr && (reg_sel == SEL_ADDR) && !busy;
  assign wr_cnt     = reg_wr && (reg_sel == SEL_CNT)  && !busy;
  assign wr_ctrl    = reg_wr && (reg_sel == SEL_CTRL) && !busy;
  assign go_pulse   = wr_ctrl && reg_wdata[CTRL_GO];
  assign stat_touch = (reg_wr || reg_rd) && (reg_sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      count      <= '0;
      mode_steal <= 1'b0;
      dir        <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (wr_addr)
        addr <= reg_wdata[AW-1:0];
      else if (step)
        addr <= addr_next(addr);

      if (wr_cnt)
        count <= reg_wdata[CW-1:0];
      else if (step)
        count <= count_next(count);

      if (wr_ctrl) begin
        mode_steal <= reg_wdata[CTRL_STEAL];
        dir        <= reg_wdata[CTRL_DIR];
      end

      if (finish)
        done <= 1'b1;
      else if (stat_touch || go_pulse)
        done <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_ADDR: reg_rdata[AW-1:0] = addr;
      SEL_CNT:  reg_rdata[CW-1:0] = count;
      SEL_CTRL: begin
        reg_rdata[CTRL_STEAL] = mode_steal;
        reg_rdata[CTRL_DIR]   = dir;
      end
      default: begin
        reg_rdata[STAT_BUSY] = busy;
        reg_rdata[STAT_DONE] = done;
      end
    endcase
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_pulse,
  input  logic [CW-1:0] count,
  input  logic          mode_steal,
  input  logic          bus_grant,
  output logic          bus_req,
  output logic          step,
  output logic          finish,
  output logic          busy
);
  dma_state_e state, state_nx;
  logic count_zero, count_last;

  assign count_zero = (count == '0);
  assign count_last = (count == CW'(1));

  always_comb begin
    state_nx = state;
    bus_req  = 1'b0;
    step     = 1'b0;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (go_pulse) begin
          if (count_zero) finish   = 1'b1;
          else            state_nx = ST_REQ;
        end
      end
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_grant) state_nx = ST_XFER;
      end
      ST_XFER: begin
        bus_req = 1'b1;
        if (bus_grant) begin
          step = 1'b1;
          if (count_last || mode_steal) state_nx = ST_REL;
        end
      end
      default: begin
        if (!bus_grant) begin
          if (count_zero) begin
            finish   = 1'b1;
            state_nx = ST_IDLE;
          end else begin
            state_nx = ST_REQ;
          end
        end
      end
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_rd,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  output logic          irq
);
  logic [AW-1:0] addr;
  logic [CW-1:0] count;
  logic          mode_steal, dir, go_pulse, done;
  logic          busy, step, finish;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .step       (step),
    .finish     (finish),
    .addr       (addr),
    .count      (count),
    .mode_steal (mode_steal),
    .dir        (dir),
    .go_pulse   (go_pulse),
    .done       (done)
  );

  dma_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_pulse   (go_pulse),
    .count      (count),
    .mode_steal (mode_steal),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .step       (step),
    .finish     (finish),
    .busy       (busy)
  );

  assign bus_oe    = step;
  assign bus_addr  = step ? addr : '0;
  assign mem_we    = step && !dir;
  assign dev_rd    = step && !dir;
  assign mem_re    = step && dir;
  assign dev_wr    = step && dir;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign irq       = done;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_sel,
  input logic          reg_rd,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          bus_oe,
  input logic [AW-1:0] bus_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          irq,
  input logic          step,
  input logic          finish,
  input logic          go_pulse,
  input logic          mode_steal,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] count
);
  a_r1_drive_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe || mem_we || mem_re) |-> (bus_grant && bus_req));

  a_r2_quiet_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_addr == '0));

  a_r4_block_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode_steal && count != CW'(1)) |=> bus_req);

  a_r5_steal_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_steal) |=> !bus_req);

  a_r7_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_STAT && !finish) |=> !irq);

  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && count == '0) |=> (irq && !bus_req));

  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr == AW'($past(addr) + AW'(1))));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == CW'($past(count) - CW'(1))));
endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_rd     (reg_rd),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .bus_oe     (bus_oe),
  .bus_addr   (bus_addr),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .irq        (irq),
  .step       (step),
  .finish     (finish),
  .go_pulse   (go_pulse),
  .mode_steal (mode_steal),
  .addr       (addr),
  .count      (count)
);

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  typedef struct packed {
    logic        steal;
    logic        dir;
    logic [15:0] addr;
    logic [15:0] cnt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0010, 16'd4},
    '{1'b1, 1'b0, 16'h0020, 16'd3},
    '{1'b0, 1'b1, 16'h0080, 16'd5},
    '{1'b1, 1'b1, 16'h0090, 16'd2},
    '{1'b0, 1'b0, 16'h0030, 16'd1},
    '{1'b0, 1'b0, 16'h0040, 16'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          bus_req, bus_grant, bus_oe;
  logic [AW-1:0] bus_addr;
  logic          mem_we, mem_re, dev_rd, dev_wr, irq;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

  logic          hold = 1'b0;
  logic [1:0]    cyc;
  logic [15:0]   dev_ptr, sink_ptr;
  logic [DW-1:0] wmem [256];
  logic [DW-1:0] sink [256];
  int            tenures, oe_cycles, req_rises, viol_drive, viol_addr, viol_req;
  logic          prev_req, prev_grant;
  int            errors = 0;
  int            checks = 0;
  int            cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_oe(bus_oe), .bus_addr(bus_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .irq(irq)
  );

  // processor stub: grants at instruction boundaries, holds grant while requested
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_grant <= 1'b0;
      cyc       <= '0;
    end else begin
      cyc       <= cyc + 2'd1;
      bus_grant <= bus_req && !hold && (bus_grant || cyc == 2'd3);
    end
  end

  assign mem_rdata = 16'h5000 + bus_addr;
  assign dev_rdata = 16'hA000 + dev_ptr;

  // memory, device and bus monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      dev_ptr <= '0; sink_ptr <= '0;
      tenures <= 0; oe_cycles <= 0; req_rises <= 0;
      viol_drive <= 0; viol_addr <= 0; viol_req <= 0;
      prev_req <= 1'b0; prev_grant <= 1'b0;
    end else begin
      if (mem_we) wmem[bus_addr[7:0]] <= mem_wdata;
      if (dev_rd) dev_ptr <= dev_ptr + 16'd1;
      if (dev_wr) begin
        sink[sink_ptr[7:0]] <= dev_wdata;
        sink_ptr <= sink_ptr + 16'd1;
      end
      if (bus_oe) oe_cycles <= oe_cycles + 1;
      if (bus_grant && !prev_grant) tenures <= tenures + 1;
      if (bus_req && !prev_req) req_rises <= req_rises + 1;
      if ((bus_oe || mem_we || mem_re || dev_rd || dev_wr) && !(bus_grant && bus_req))
        viol_drive <= viol_drive + 1;
      if (!bus_oe && bus_addr != '0) viol_addr <= viol_addr + 1;
      if (bus_req && !prev_req && bus_grant) viol_req <= viol_req + 1;
      prev_req   <= bus_req;
      prev_grant <= bus_grant;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [DW-1:0] rd;
    int t0, o0, r0;
    logic [15:0] d0, s0;

    repeat (3) @(negedge clk);
    // reset state
    chk("R7 irq after reset", 32'(irq), 32'd0);
    chk("R1 bus_req after reset", 32'(bus_req), 32'd0);
    chk("R2 bus_addr after reset", 32'(bus_addr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_sel = 2'd3; #1;
    chk("R3 status after reset", 32'(reg_rdata), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VECS[v];
      reg_write(2'd0, e.addr);
      reg_write(2'd1, e.cnt);
      t0 = tenures; o0 = oe_cycles; r0 = req_rises; d0 = dev_ptr; s0 = sink_ptr;
      reg_write(2'd2, {13'd0, e.dir, e.steal, 1'b1});
      wait_irq();
      chk("R7 irq at completion", 32'(irq), 32'd1);
      reg_read(2'd0, rd);
      chk("R10 final address", 32'(rd), 32'(e.addr + e.cnt));
      reg_read(2'd1, rd);
      chk("R10 final count", 32'(rd), 32'd0);
      reg_read(2'd2, rd);
      chk("R3 control readback", 32'(rd), 32'({e.dir, e.steal, 1'b0}));
      chk("R12 bus cycles", 32'(oe_cycles - o0), 32'(e.cnt));
      if (e.cnt == 0)
        chk("R9 no request on zero count", 32'(req_rises - r0), 32'd0);
      else if (e.steal)
        chk("R5 one grant per word", 32'(tenures - t0), 32'(e.cnt));
      else
        chk("R4 single tenure", 32'(tenures - t0), 32'd1);
      for (int i = 0; i < int'(e.cnt); i++) begin
        if (!e.dir)
          chk("R12 device to memory", 32'(wmem[8'(e.addr + 16'(i))]), 32'(16'hA000 + d0 + 16'(i)));
        else
          chk("R12 memory to device", 32'(sink[8'(s0 + 16'(i))]), 32'(16'h5000 + e.addr + 16'(i)));
      end
      reg_read(2'd3, rd);
      chk("R8 done bit before clear", 32'(rd), 32'h2);
      #1 chk("R8 irq cleared by status read", 32'(irq), 32'd0);
    end

    // ignored writes while busy
    reg_write(2'd0, 16'h0060);
    reg_write(2'd1, 16'd2);
    hold = 1'b1;
    d0 = dev_ptr;
    reg_write(2'd2, 16'h0001);
    reg_write(2'd0, 16'h0070);
    reg_write(2'd1, 16'd9);
    reg_write(2'd2, 16'h0007);
    reg_read(2'd3, rd);
    chk("R3 busy while waiting grant", 32'(rd), 32'h1);
    chk("R6 request held without grant", 32'(bus_req), 32'd1);
    hold = 1'b0;
    wait_irq();
    chk("R11 irq after guarded run", 32'(irq), 32'd1);
    reg_read(2'd0, rd);
    chk("R11 address write ignored", 32'(rd), 32'h0062);
    reg_read(2'd2, rd);
    chk("R11 control write ignored", 32'(rd), 32'd0);
    chk("R11 data at original address", 32'(wmem[8'h61]), 32'(16'hA001 + d0));

    // status write clears done
    reg_write(2'd3, 16'h0000);
    #1 chk("R8 irq cleared by status write", 32'(irq), 32'd0);

    // zero count done one edge after start
    reg_write(2'd1, 16'd0);
    @(negedge clk);
    reg_sel = 2'd2; reg_wdata = 16'h0001; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 done one edge after start", 32'(irq), 32'd1);
    chk("R9 no bus request", 32'(bus_req), 32'd0);

    repeat (4) @(negedge clk);
    chk("R1 no drive without grant", 32'(viol_drive), 32'd0);
    chk("R2 address zero when idle", 32'(viol_addr), 32'd0);
    chk("R6 no request under stale grant", 32'(viol_req), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule